// File: doc/BRIEF.md
# Dual-Register Phase-Modulated NCO

This block is a numerically controlled oscillator for driving a 10-bit DAC. A 28-bit phase accumulator adds the active frequency tuning word on every clock and wraps modulo 2^28. The output frequency is therefore tuning_word × f_clk / 2^28. The top 12 bits of the accumulator are offset by the active 12-bit phase word. The sum wraps modulo 4096. The resulting phase drives a quarter-wave sine table, and the table produces a registered 10-bit sample.

Two tuning words and two phase words are held locally and written through a parallel write port. The active tuning word and the active phase word are each chosen in one of two ways, depending on a source bit in a small control word: from dedicated select pins, or from bits in that same control word. Changing the active tuning word changes only the step size, and the accumulated phase is left as it is. This gives frequency-shift keying with a continuous phase. Changing the active phase word gives phase-shift keying.

Top module: `phase_mod_nco`

## Requirements
- R1: Every clock out of reset, the 28-bit accumulator advances by the active tuning word, modulo 2^28. A word of 28'hFFFFFFF therefore makes the phase run backwards by one step.
- R2: The active tuning word is selected by control bit 2. When it is 1, the `fsel_i` pin chooses (0 selects tuning word 0, 1 selects tuning word 1). When it is 0, control bit 0 chooses.
- R3: Changing the active tuning word neither clears nor jumps the accumulator. From the next clock the phase continues from its current value with the new step.
- R4: The active phase word is chosen by the same control bit 2, from `psel_i` or from control bit 1. It is added to accumulator bits [27:16], and the sum wraps modulo 4096.
- R5: Accumulator bits [15:0] never affect the sample. Only the 12-bit phase reaches the table.
- R6: For table phase p, let s = sin(2π(p+0.5)/4096). The sample is 512+round(511·s) when s ≥ 0 and 511−round(−511·s) otherwise, within ±1 LSB. The sample MSB is 1 exactly when p[11] is 0.
- R7: When `wr_en` is high at a rising edge, `wr_addr` selects the target register: 0 is tuning word 0, 1 is tuning word 1, 2 is phase word 0, 3 is phase word 1, and 4 is the control word. The register takes `wr_data` at that edge. Addresses 5 to 7 change nothing.
- R8: A synchronous active-high `rst` clears the accumulator, the phase register, the four words and the control word. While reset is held and afterwards, the sample is 512 (mid-scale, zero phase) until a non-zero word is written.
- R9: The sample after edge n is the table value of (accumulator bits [27:16] after edge n−2) plus the phase word that was active between edges n−2 and n−1.
- R10: Phase words take `wr_data[11:0]`, and the control word takes `wr_data[2:0]`. All higher data bits are dropped for those addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for a write |
| wr_data | input | 28 | Write data |
| fsel_i | input | 1 | Tuning word select pin (used when control bit 2 is 1) |
| psel_i | input | 1 | Phase word select pin (used when control bit 2 is 1) |
| sample_o | output | 10 | Offset-binary sine sample |

## Verification
The reference model is compared against the design on every clock, and the bench steps it through several kinds of stimulus. A small odd tuning word, a negative word (all ones) and a word just above half-scale exercise the accumulator's wrap and its sign behaviour. A word of exactly 2^16 walks the table through all 4096 phases, one per clock, which covers every quadrant and every mirror point of the quarter-wave table. A word of 2^16−1 moves only the discarded low bits for a cycle, which shows whether truncation is correct. Toggling the select pins, and writing the control bits, separates pin selection from register selection. Because the model carries the accumulator across every switch, any accumulator reset or one-cycle timing slip shows up as a mismatch.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int ACC_W_DEF = 28;
    localparam int PH_W_DEF  = 12;
    localparam int OUT_W_DEF = 10;

    localparam logic [2:0] ADDR_FTW0  = 3'd0;
    localparam logic [2:0] ADDR_FTW1  = 3'd1;
    localparam logic [2:0] ADDR_POFF0 = 3'd2;
    localparam logic [2:0] ADDR_POFF1 = 3'd3;
    localparam logic [2:0] ADDR_CTRL  = 3'd4;

    localparam int CTRL_FBIT = 0;
    localparam int CTRL_PBIT = 1;
    localparam int CTRL_SRC  = 2;

    // Magnitude of one quarter-wave entry, sampled at the middle of step k.
    // A Taylor series is used so only plain real arithmetic is needed.
    function automatic int quarter_mag(int k, int steps, int mag_max);
        real x;
        real term;
        real acc;
        x    = (real'(k) + 0.5) * 1.5707963267948966 / real'(steps);
        acc  = x;
        term = x;
        for (int n = 1; n < 8; n++) begin
            term = -term * x * x / real'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return $rtoi(acc * real'(mag_max) + 0.5);
    endfunction

endpackage

// File: rtl/nco_reg_bank.sv
module nco_reg_bank #(
    parameter int ACC_W = nco_pkg::ACC_W_DEF,
    parameter int PH_W  = nco_pkg::PH_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [ACC_W-1:0] wr_data,
    output logic [ACC_W-1:0] ftw0_o,
    output logic [ACC_W-1:0] ftw1_o,
    output logic [PH_W-1:0]  poff0_o,
    output logic [PH_W-1:0]  poff1_o,
    output logic [2:0]       ctrl_o
);
    import nco_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            ftw0_o  <= '0;
            ftw1_o  <= '0;
            poff0_o <= '0;
            poff1_o <= '0;
            ctrl_o  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_FTW0:  ftw0_o  <= wr_data;
                ADDR_FTW1:  ftw1_o  <= wr_data;
                ADDR_POFF0: poff0_o <= wr_data[PH_W-1:0];
                ADDR_POFF1: poff1_o <= wr_data[PH_W-1:0];
                ADDR_CTRL:  ctrl_o  <= wr_data[2:0];
                default:    ;
            endcase
        end
    end

    AST_UNUSED_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > ADDR_CTRL) |=> ($stable(ftw0_o) && $stable(ftw1_o) &&
        $stable(poff0_o) && $stable(poff1_o) && $stable(ctrl_o))); // R7

endmodule

// File: rtl/nco_phase_path.sv
module nco_phase_path #(
    parameter int ACC_W = nco_pkg::ACC_W_DEF,
    parameter int PH_W  = nco_pkg::PH_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] step_i,
    input  logic [PH_W-1:0]  offset_i,
    output logic [PH_W-1:0]  phase_o
);
    localparam int DROP = ACC_W - PH_W;

    logic [ACC_W-1:0] acc_q;

    // Accumulator wraps naturally at its width; the offset sum wraps at PH_W.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            phase_o <= '0;
        end else begin
            acc_q   <= acc_q + step_i;
            phase_o <= acc_q[ACC_W-1:DROP] + offset_i;
        end
    end

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (acc_q == '0 && phase_o == '0)); // R8

endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut #(
    parameter int PH_W       = nco_pkg::PH_W_DEF,
    parameter int OUT_W      = nco_pkg::OUT_W_DEF,
    parameter bit SIGNED_OUT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PH_W-1:0]  phase_i,
    output logic [OUT_W-1:0] sample_o
);
    localparam int IDX_W   = PH_W - 2;
    localparam int LUT_N   = 1 << IDX_W;
    localparam int MAG_W   = OUT_W - 1;
    localparam int MAG_MAX = (1 << MAG_W) - 1;
    localparam logic [OUT_W-1:0] MID = OUT_W'(1 << MAG_W);
    localparam logic [OUT_W-1:0] RST_VAL = SIGNED_OUT ? '0 : MID;

    logic [MAG_W-1:0] rom [LUT_N];

    for (genvar k = 0; k < LUT_N; k++) begin : g_rom
        localparam logic [MAG_W-1:0] ENTRY =
            MAG_W'(nco_pkg::quarter_mag(k, LUT_N, MAG_MAX));
        assign rom[k] = ENTRY;
    end

    logic [IDX_W-1:0] idx;
    logic [MAG_W-1:0] mag;
    logic [OUT_W-1:0] obin;
    logic [OUT_W-1:0] coded;

    always_comb begin
        idx  = phase_i[PH_W-2] ? ~phase_i[IDX_W-1:0] : phase_i[IDX_W-1:0];
        mag  = rom[idx];
        obin = phase_i[PH_W-1] ? (MID - 1'b1 - {1'b0, mag}) : (MID + {1'b0, mag});
    end

    if (SIGNED_OUT) begin : g_signed
        assign coded = {~obin[OUT_W-1], obin[OUT_W-2:0]};
    end else begin : g_offset
        assign coded = obin;

        AST_SIGN_FROM_PHASE: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (sample_o[OUT_W-1] == !$past(phase_i[PH_W-1]))); // R6
    end

    always_ff @(posedge clk) begin
        if (rst) sample_o <= RST_VAL;
        else     sample_o <= coded;
    end

    AST_SAMPLE_MID: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sample_o == RST_VAL)); // R8

endmodule

// File: rtl/phase_mod_nco.sv
module phase_mod_nco #(
    parameter int ACC_W      = nco_pkg::ACC_W_DEF,
    parameter int PH_W       = nco_pkg::PH_W_DEF,
    parameter int OUT_W      = nco_pkg::OUT_W_DEF,
    parameter bit SIGNED_OUT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             fsel_i,
    input  logic             psel_i,
    output logic [OUT_W-1:0] sample_o
);
    import nco_pkg::*;

    logic [ACC_W-1:0] ftw0, ftw1, step;
    logic [PH_W-1:0]  poff0, poff1, offset, phase;
    logic [2:0]       ctrl;
    logic             fsel_eff, psel_eff;

    nco_reg_bank #(.ACC_W(ACC_W), .PH_W(PH_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ftw0_o  (ftw0),
        .ftw1_o  (ftw1),
        .poff0_o (poff0),
        .poff1_o (poff1),
        .ctrl_o  (ctrl)
    );

    always_comb begin
        fsel_eff = ctrl[CTRL_SRC] ? fsel_i : ctrl[CTRL_FBIT];
        psel_eff = ctrl[CTRL_SRC] ? psel_i : ctrl[CTRL_PBIT];
        step     = fsel_eff ? ftw1 : ftw0;
        offset   = psel_eff ? poff1 : poff0;
    end

    AST_STEP_FROM_BANK: assert property (@(posedge clk) disable iff (rst)
        (step == ftw0 || step == ftw1)); // R2
    AST_OFFSET_FROM_BANK: assert property (@(posedge clk) disable iff (rst)
        (offset == poff0 || offset == poff1)); // R4

    nco_phase_path #(.ACC_W(ACC_W), .PH_W(PH_W)) u_path (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step),
        .offset_i (offset),
        .phase_o  (phase)
    );

    nco_sine_lut #(.PH_W(PH_W), .OUT_W(OUT_W), .SIGNED_OUT(SIGNED_OUT)) u_lut (
        .clk      (clk),
        .rst      (rst),
        .phase_i  (phase),
        .sample_o (sample_o)
    );

endmodule

// File: tb/phase_mod_nco_tb_top.sv
module phase_mod_nco_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [27:0] wr_data = '0;
    logic        fsel_i = 1'b0;
    logic        psel_i = 1'b0;
    logic [9:0]  sample_o;

    always #2 clk = ~clk;

    phase_mod_nco dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .fsel_i   (fsel_i),
        .psel_i   (psel_i),
        .sample_o (sample_o)
    );

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    bit    m_valid = 1'b0;
    string cur_tag = "R8";

    // behavioural model state
    logic [27:0] m_acc, m_f0, m_f1;
    logic [11:0] m_p0, m_p1, m_ph;
    logic [2:0]  m_ctrl;
    int          m_out;

    function automatic int ref_sine(int p);
        real s;
        s = $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 4096.0);
        if (s >= 0.0) return 512 + $rtoi(511.0 * s + 0.5);
        return 511 - $rtoi(-511.0 * s + 0.5);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_acc = '0; m_f0 = '0; m_f1 = '0;
            m_p0 = '0; m_p1 = '0; m_ph = '0; m_ctrl = '0;
            m_out = 512;
            m_valid = 1'b1;
        end else if (m_valid) begin
            logic fs, ps;
            logic [27:0] stp;
            logic [11:0] off;
            fs  = m_ctrl[2] ? fsel_i : m_ctrl[0];
            ps  = m_ctrl[2] ? psel_i : m_ctrl[1];
            stp = fs ? m_f1 : m_f0;
            off = ps ? m_p1 : m_p0;
            m_out = ref_sine(int'(m_ph));
            m_ph  = m_acc[27:16] + off;
            m_acc = m_acc + stp;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_f0 = wr_data;
                    3'd1: m_f1 = wr_data;
                    3'd2: m_p0 = wr_data[11:0];
                    3'd3: m_p1 = wr_data[11:0];
                    3'd4: m_ctrl = wr_data[2:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string tag, int got, int exp, int tol);
        int d;
        checks++;
        d = got - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            failures++;
            $display("FAIL %s sample got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // compare against the model on every clock, away from the rising edge
    always @(negedge clk) begin
        if (m_valid && !done) check(cur_tag, int'(sample_o), m_out, rst ? 0 : 1);
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(logic [2:0] a, logic [27:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cycles(3);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired before the run completed");
        finish_run();
    end

    initial begin
        // R8: reset state
        cur_tag = "R8";
        cycles(4);
        rst = 1'b0;
        cycles(5);
        check("R8 idle after reset", int'(sample_o), 512, 0);

        // R1: plain accumulation, negative step, near half-scale step
        cur_tag = "R1";
        write_reg(3'd0, 28'h0123457);
        cycles(300);
        write_reg(3'd0, 28'hFFFFFFF);
        cycles(40);
        write_reg(3'd0, 28'h8000001);
        cycles(60);

        // R2 and R3: register-selected then pin-selected tuning word
        cur_tag = "R2";
        write_reg(3'd1, 28'h0400000);
        write_reg(3'd4, 28'h0000001);
        cycles(40);
        cur_tag = "R3";
        write_reg(3'd4, 28'h0000004);
        for (int i = 0; i < 16; i++) begin
            fsel_i = ~fsel_i;
            cycles(7);
        end

        // R4 and R10: phase words, upper data bits discarded
        cur_tag = "R10";
        write_reg(3'd2, 28'hABCD400);
        write_reg(3'd3, 28'h5555C00);
        cur_tag = "R4";
        for (int i = 0; i < 14; i++) begin
            psel_i = ~psel_i;
            cycles(5);
        end
        write_reg(3'd4, 28'hFFFFFFA);
        cycles(30);

        // R7: writes to unused addresses change nothing
        cur_tag = "R7";
        write_reg(3'd5, 28'h1234567);
        write_reg(3'd6, 28'hFFFFFFF);
        write_reg(3'd7, 28'h0AAAAAA);
        cycles(30);

        // R8: reset mid-run
        cur_tag = "R8";
        do_reset();
        cycles(2);
        check("R8 mid-run reset", int'(sample_o), 512, 0);

        // R5: only low accumulator bits move at first
        cur_tag = "R5";
        write_reg(3'd0, 28'h000FFFF);
        cycles(40);

        // R9: large steps expose any latency slip
        cur_tag = "R9";
        do_reset();
        write_reg(3'd0, 28'h1230000);
        write_reg(3'd2, 28'h0000123);
        cycles(40);

        // R6: sweep every table phase once
        cur_tag = "R6";
        do_reset();
        write_reg(3'd0, 28'h0010000);
        cycles(4200);

        finish_run();
    end

endmodule